// File: doc/BRIEF.md
# Masked Data-Parallel Element Array

This block is a small data-parallel engine. A row of identical processing elements each keep one 32-bit unsigned record, such as a salary, in a local register. One control unit takes commands from a single port and broadcasts each one to every element at once. The elements never fetch or sequence instructions of their own.

Each element has an enable flag. A broadcast multiply changes only the elements whose flag is set. A conditional update is therefore a pair of masked passes under one command stream, and no element takes a branch of its own. The main use is a two-rate raise. A compare builds a mask of the records above a limit, and a first multiply scales those records. The mask is then inverted, and a second multiply scales the remaining records. Together the two passes form one logical step.

Multipliers are unsigned fixed-point values with 16 fraction bits. Each product is shifted right by 16, and its upper bits are then dropped to keep 32 bits. The host loads and reads single records by index over the same command port.

Top module: `simd_pe_array`

## Requirements
- R1: After reset, cmd_ready is 1, rd_valid is 0, every stored record is 0 and every enable flag is set.
- R2: Opcode 0 (store) writes cmd_data into the record chosen by cmd_idx. Opcode 5 (fetch) returns the chosen record on rd_data, with rd_valid high for the one cycle after the command is accepted.
- R3: Opcode 1 (compare) sets each enable flag if and only if that element's record is strictly greater than cmd_data. A record equal to cmd_data is disabled.
- R4: Opcode 2 (invert) flips every enable flag, so applying it twice restores the mask.
- R5: Opcode 3 (enable all) sets every enable flag.
- R6: Opcode 4 (scale) replaces every enabled record v with bits [47:16] of v times cmd_data (cmd_data is a multiplier with 16 fraction bits). Disabled records keep their value.
- R7: A scale command drops cmd_ready for exactly the one cycle after it is accepted, and the new records are visible after that cycle. No other command drops cmd_ready.
- R8: A compare against 100000, a scale by 68813, an invert and a scale by 72090 multiply records above 100000 by 1.05 and all other records by 1.10, each with truncation.
- R9: Opcodes 6 and 7 are accepted and change neither the records nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Opcode |
| cmd_idx | input | 3 | Element index for store and fetch |
| cmd_data | input | 32 | Store value, compare limit or multiplier |
| rd_valid | output | 1 | Fetch result valid |
| rd_data | output | 32 | Fetched record |

## Verification
The two-pass raise runs on a set of records chosen to separate the cases. The set includes values just below, exactly at and just above 100000, where the value equal to the limit shows whether the compare is strict. Zero and the all-ones value check the truncation of the shifted product. Directed sequences then apply a compare that disables every element, enable-all, a double invert and the unused opcodes. Each of these is followed by a scale whose outcome shows the mask state at the ports.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_STORE = 3'd0,
    OP_CMPGT = 3'd1,
    OP_INV   = 3'd2,
    OP_ALL   = 3'd3,
    OP_SCALE = 3'd4,
    OP_FETCH = 3'd5
  } op_e;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic [NUM_PE-1:0] st_en,
  output logic              gt_en,
  output logic              inv_en,
  output logic              all_en,
  output logic              scale_en,
  output logic [DATA_W-1:0] mult,
  output logic              fetch_en
);
  import simd_pkg::*;

  logic              busy_q, busy_d;
  logic [DATA_W-1:0] mult_q, mult_d;
  logic              accept;

  assign cmd_ready = ~busy_q;
  assign accept    = cmd_valid & ~busy_q;

  always_comb begin
    busy_d = accept && (cmd_op == OP_SCALE);
    mult_d = busy_d ? cmd_data : mult_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mult_q <= '0;
    end else begin
      busy_q <= busy_d;
      mult_q <= mult_d;
    end
  end

  assign gt_en    = accept && (cmd_op == OP_CMPGT);
  assign inv_en   = accept && (cmd_op == OP_INV);
  assign all_en   = accept && (cmd_op == OP_ALL);
  assign fetch_en = accept && (cmd_op == OP_FETCH);
  assign scale_en = busy_q;
  assign mult     = mult_q;

  for (genvar i = 0; i < NUM_PE; i++) begin : g_sel
    assign st_en[i] = accept && (cmd_op == OP_STORE) && (cmd_idx == IDX_W'(i));
  end

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q); // R7
endmodule

// File: rtl/simd_pe.sv
module simd_pe #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  logic [DATA_W-1:0] st_data,
  input  logic              gt_en,
  input  logic              inv_en,
  input  logic              all_en,
  input  logic              scale_en,
  input  logic [DATA_W-1:0] mult,
  output logic [DATA_W-1:0] value,
  output logic              enabled
);
  logic [DATA_W-1:0]   val_q, val_d;
  logic                en_q, en_d;
  logic [2*DATA_W-1:0] prod;

  assign prod = {{DATA_W{1'b0}}, val_q} * {{DATA_W{1'b0}}, mult};

  always_comb begin
    val_d = val_q;
    if (st_en)                val_d = st_data;
    else if (scale_en && en_q) val_d = prod[FRAC_W +: DATA_W];
    en_d = en_q;
    if (gt_en)       en_d = (val_q > st_data);
    else if (inv_en) en_d = ~en_q;
    else if (all_en) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      en_q  <= 1'b1;
    end else begin
      val_q <= val_d;
      en_q  <= en_d;
    end
  end

  assign value   = val_q;
  assign enabled = en_q;

  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |=> val_q == $past(st_data)); // R2
  AST_EQUAL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (gt_en && val_q == st_data) |=> !en_q); // R3
  AST_INV_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> en_q != $past(en_q)); // R4
  AST_ALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    all_en |=> en_q); // R5
  AST_MASKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_en && !en_q) |=> $stable(val_q)); // R6
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16,
  localparam int IDX_W = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [NUM_PE-1:0]             st_en;
  logic [NUM_PE-1:0]             en_vec;
  logic [NUM_PE-1:0][DATA_W-1:0] vals;
  logic                          gt_en, inv_en, all_en, scale_en, fetch_en;
  logic [DATA_W-1:0]             mult;
  logic                          rdv_q, rdv_d;
  logic [DATA_W-1:0]             rdd_q, rdd_d;

  simd_ctrl #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .st_en(st_en), .gt_en(gt_en), .inv_en(inv_en), .all_en(all_en),
    .scale_en(scale_en), .mult(mult), .fetch_en(fetch_en)
  );

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    simd_pe #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_pe (
      .clk(clk), .rst_n(rst_n), .st_en(st_en[i]), .st_data(cmd_data),
      .gt_en(gt_en), .inv_en(inv_en), .all_en(all_en),
      .scale_en(scale_en), .mult(mult), .value(vals[i]), .enabled(en_vec[i])
    );
  end

  always_comb begin
    rdv_d = fetch_en;
    rdd_d = fetch_en ? vals[cmd_idx] : rdd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else begin
      rdv_q <= rdv_d;
      rdd_q <= rdd_d;
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd4) |=> !cmd_ready); // R7
  AST_FETCH_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd5) |=> rd_valid); // R2
  AST_ALL_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd3) |=> $countones(en_vec) == NUM_PE); // R5
endmodule

// File: tb/sim_simd_pe_array.sv
`timescale 1ns/1ps
module sim_simd_pe_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_idx = 3'd0;
  logic [31:0] cmd_data = 32'd0;
  logic        cmd_ready, rd_valid;
  logic [31:0] rd_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simd_pe_array u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  localparam logic [31:0] VEC [8] = '{32'd100000, 32'd100001, 32'd0, 32'hFFFFFFFF,
                                      32'd50000, 32'd250000, 32'd99999, 32'd1};
  localparam logic [31:0] K_HI = 32'd68813;
  localparam logic [31:0] K_LO = 32'd72090;

  function automatic logic [31:0] scale(input logic [31:0] v, input logic [31:0] k);
    logic [63:0] p;
    p = {32'd0, v} * {32'd0, k};
    return p[47:16];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic fetch(input logic [2:0] idx, output logic [31:0] v);
    send(3'd5, idx, 32'd0);
    chk("R2 rd_valid", {31'd0, rd_valid}, 32'd1);
    v = rd_data;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk("R1 ready", {31'd0, cmd_ready}, 32'd1);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    fetch(3'd3, r);
    chk("R1 record zero", r, 32'd0);
    @(negedge clk);
    chk("R2 rd_valid pulse", {31'd0, rd_valid}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      send(3'd0, 3'(i), VEC[i]);
      chk("R7 ready after store", {31'd0, cmd_ready}, 32'd1);
    end
    for (int i = 0; i < 8; i++) begin
      fetch(3'(i), r);
      chk("R2 store/fetch", r, VEC[i]);
    end
    send(3'd1, 3'd0, 32'd100000);
    send(3'd4, 3'd0, K_HI);
    chk("R7 ready low", {31'd0, cmd_ready}, 32'd0);
    @(negedge clk);
    chk("R7 ready back", {31'd0, cmd_ready}, 32'd1);
    send(3'd2, 3'd0, 32'd0);
    send(3'd4, 3'd0, K_LO);
    for (int i = 0; i < 8; i++) begin
      fetch(3'(i), r);
      chk("R8 two-pass", r, (VEC[i] > 32'd100000) ? scale(VEC[i], K_HI) : scale(VEC[i], K_LO));
    end

    // R3: equal to limit stays disabled, nothing above all-ones
    send(3'd0, 3'd0, 32'hFFFFFFFF);
    send(3'd0, 3'd1, 32'd7);
    send(3'd1, 3'd0, 32'hFFFFFFFF);
    send(3'd4, 3'd0, 32'h00020000);
    fetch(3'd0, r); chk("R3 equal disabled", r, 32'hFFFFFFFF);
    fetch(3'd1, r); chk("R3 below disabled", r, 32'd7);
    // R5: enable all then double (R6 truncation)
    send(3'd3, 3'd0, 32'd0);
    send(3'd4, 3'd0, 32'h00020000);
    fetch(3'd0, r); chk("R5/R6 truncated", r, 32'hFFFFFFFE);
    fetch(3'd1, r); chk("R5 enabled", r, 32'd14);
    // R4: double invert restores all-enabled mask
    send(3'd2, 3'd0, 32'd0);
    send(3'd2, 3'd0, 32'd0);
    send(3'd4, 3'd0, 32'h00030000);
    fetch(3'd1, r); chk("R4 double invert", r, 32'd42);
    // R4: single invert disables all
    send(3'd2, 3'd0, 32'd0);
    send(3'd4, 3'd0, 32'h00030000);
    fetch(3'd1, r); chk("R4 single invert", r, 32'd42);
    // R9: unused opcodes touch neither record nor mask (mask still all off)
    send(3'd6, 3'd1, 32'd99);
    send(3'd7, 3'd1, 32'd99);
    fetch(3'd1, r); chk("R9 record kept", r, 32'd42);
    send(3'd4, 3'd0, 32'h00030000);
    fetch(3'd1, r); chk("R9 mask kept", r, 32'd42);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule